// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for the instruction currently in the execute stage of a five-stage in-order integer pipeline, where each ALU operand should come from. It looks at the two source register numbers of that instruction. It compares them with the destination register numbers and register-write flags held in the two younger pipeline latches: the execute/memory latch and the memory/writeback latch. For each operand it then drives a 2-bit mux select. The select picks one of three values: the register-file read, the execute/memory result, or the memory/writeback result.

The block also drives a one-bit select for the write-data input of the data memory. When a load sits in memory/writeback and the store directly behind it, now in execute/memory, stores the register the load just wrote, the select routes the loaded value to the memory write port. This avoids a stall for a memory-to-memory copy.

The unit holds no state. All three selects are pure functions of the current inputs and settle in the same cycle. The pipeline latches, the ALU, the register file and stall generation all sit outside it.

Top module: `fwd_unit`

## Requirements
- R1: An operand select reads 2'b00 (register-file value) when neither younger stage qualifies as a producer for that source. The code 2'b11 is never driven.
- R2: An operand select reads 2'b10 when the execute/memory write flag is 1, its destination is nonzero, and its destination equals the source (rs for operand A, rt for operand B).
- R3: An operand select reads 2'b01 when the memory/writeback stage qualifies for that source (write flag 1, nonzero destination, equal to the source) and the execute/memory stage does not qualify.
- R4: When both stages qualify for the same source, the select reads 2'b10, so the most recent producer wins.
- R5: A destination of register 0 is never forwarded from either stage, whatever the write flags are.
- R6: A stage whose write flag is 0 is never forwarded from, even when its destination matches.
- R7: Operand A (from rs) and operand B (from rt) are decided independently, and both may be forwarded in the same cycle, from the same stage or from different stages.
- R8: The store-data select is 1 exactly when all of these hold: execute/memory holds a store, memory/writeback holds a load with its write flag 1, the load's destination is nonzero, and that destination equals the store's data register. Otherwise the select is 0.
- R9: All selects follow their inputs combinationally, with no clock edge between an input change and the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs | input | REG_AW | First source register number of the execute-stage instruction |
| ex_rt | input | REG_AW | Second source register number of the execute-stage instruction |
| xm_wr | input | 1 | Register-write flag in the execute/memory latch |
| xm_rd | input | REG_AW | Destination register number in the execute/memory latch |
| xm_store | input | 1 | Execute/memory latch holds a store |
| xm_src | input | REG_AW | Data register of the store in execute/memory |
| mw_wr | input | 1 | Register-write flag in the memory/writeback latch |
| mw_rd | input | REG_AW | Destination register number in the memory/writeback latch |
| mw_load | input | 1 | Memory/writeback latch holds a load |
| sel_a | output | 2 | ALU operand A select (00 file, 10 exe/mem, 01 mem/wb) |
| sel_b | output | 2 | ALU operand B select (same encoding) |
| sel_st | output | 1 | Data-memory write-data select (1 = loaded value from mem/wb) |

## Verification
The bench aims at the collisions where a forwarding unit most easily goes wrong. Both stages write the same register: a design with the priority inverted would feed a stale result from the older stage. A stage writes register 0: a design missing the zero guard would overwrite the hard-wired zero operand. A write flag is clear but the destination matches: a design that ignores the flag would forward from a branch or a store. Randomized vectors draw register numbers from a tiny range so that rs equals rt and both stages collide often. They also cover the store path under every combination of load, store and flag, so a wrong polarity or a missing condition there shows up as a spurious or missing store-data bypass.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_FILE = 2'b00,
    SRC_MW   = 2'b01,
    SRC_XM   = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_AW = 5
) (
  input  logic              wr,
  input  logic [REG_AW-1:0] dst,
  input  logic [REG_AW-1:0] src,
  output logic              hit
);
  always_comb begin
    hit = wr && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/fwd_opnd_sel.sv
module fwd_opnd_sel
  import fwd_pkg::*;
(
  input  logic      hit_young,
  input  logic      hit_old,
  output opnd_src_e sel
);
  always_comb begin
    if (hit_young)    sel = SRC_XM;
    else if (hit_old) sel = SRC_MW;
    else              sel = SRC_FILE;
  end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
  parameter int REG_AW = 5
) (
  input  logic              store,
  input  logic [REG_AW-1:0] st_src,
  input  logic              ld_wr,
  input  logic              ld,
  input  logic [REG_AW-1:0] ld_rd,
  output logic              sel
);
  logic ld_hit;

  fwd_match #(.REG_AW(REG_AW)) u_hit (
    .wr (ld_wr && ld),
    .dst(ld_rd),
    .src(st_src),
    .hit(ld_hit)
  );

  always_comb begin
    sel = store && ld_hit;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic              xm_wr,
  input  logic [REG_AW-1:0] xm_rd,
  input  logic              xm_store,
  input  logic [REG_AW-1:0] xm_src,
  input  logic              mw_wr,
  input  logic [REG_AW-1:0] mw_rd,
  input  logic              mw_load,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              sel_st
);
  localparam int NUM_OPND = 2;

  logic [REG_AW-1:0] src_q [NUM_OPND];
  opnd_src_e         sel_q [NUM_OPND];

  always_comb begin
    src_q[0] = ex_rs;
    src_q[1] = ex_rt;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    logic hit_xm;
    logic hit_mw;

    fwd_match #(.REG_AW(REG_AW)) u_xm (
      .wr (xm_wr),
      .dst(xm_rd),
      .src(src_q[g]),
      .hit(hit_xm)
    );

    fwd_match #(.REG_AW(REG_AW)) u_mw (
      .wr (mw_wr),
      .dst(mw_rd),
      .src(src_q[g]),
      .hit(hit_mw)
    );

    fwd_opnd_sel u_sel (
      .hit_young(hit_xm),
      .hit_old  (hit_mw),
      .sel      (sel_q[g])
    );
  end

  fwd_store_sel #(.REG_AW(REG_AW)) u_st (
    .store (xm_store),
    .st_src(xm_src),
    .ld_wr (mw_wr),
    .ld    (mw_load),
    .ld_rd (mw_rd),
    .sel   (sel_st)
  );

  always_comb begin
    sel_a = sel_q[0];
    sel_b = sel_q[1];
  end
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_rs,
  input logic [REG_AW-1:0] ex_rt,
  input logic              xm_wr,
  input logic [REG_AW-1:0] xm_rd,
  input logic              xm_store,
  input logic [REG_AW-1:0] xm_src,
  input logic              mw_wr,
  input logic [REG_AW-1:0] mw_rd,
  input logic              mw_load,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic              sel_st
);
  logic known;

  always_comb begin
    known = !$isunknown({ex_rs, ex_rt, xm_wr, xm_rd, xm_store, xm_src,
                         mw_wr, mw_rd, mw_load, sel_a, sel_b, sel_st});
    if (known) begin
      assert_no_code3_R1: assert (sel_a != 2'b11 && sel_b != 2'b11);
      if (xm_wr && xm_rd != '0 && xm_rd == ex_rs)
        assert_young_wins_a_R4: assert (sel_a == 2'b10);
      if (xm_wr && xm_rd != '0 && xm_rd == ex_rt)
        assert_young_wins_b_R2: assert (sel_b == 2'b10);
      if (sel_a == 2'b01)
        assert_old_valid_a_R3: assert (mw_wr && mw_rd == ex_rs && mw_rd != '0);
      if (sel_b != 2'b00)
        assert_flag_needed_b_R6: assert (xm_wr || mw_wr);
      if (ex_rs == '0)
        assert_zero_never_a_R5: assert (sel_a == 2'b00);
      if (ex_rt == '0)
        assert_zero_never_b_R5: assert (sel_b == 2'b00);
      if (sel_st)
        assert_store_path_R8: assert (xm_store && mw_load && mw_wr && mw_rd == xm_src);
    end
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .ex_rs(ex_rs), .ex_rt(ex_rt), .xm_wr(xm_wr), .xm_rd(xm_rd),
  .xm_store(xm_store), .xm_src(xm_src), .mw_wr(mw_wr), .mw_rd(mw_rd),
  .mw_load(mw_load), .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st)
);

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [AW-1:0] ex_rs, ex_rt, xm_rd, xm_src, mw_rd;
  logic xm_wr, xm_store, mw_wr, mw_load;
  logic [1:0] sel_a, sel_b;
  logic sel_st;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  fwd_unit #(.REG_AW(AW)) dut (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .xm_wr(xm_wr), .xm_rd(xm_rd),
    .xm_store(xm_store), .xm_src(xm_src), .mw_wr(mw_wr), .mw_rd(mw_rd),
    .mw_load(mw_load), .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st)
  );

  // reference: which producer feeds a source, as a select code
  function automatic logic [1:0] ref_sel(input int src);
    int newest = -1;
    if (mw_wr && int'(mw_rd) != 0 && int'(mw_rd) == src) newest = 1;
    if (xm_wr && int'(xm_rd) != 0 && int'(xm_rd) == src) newest = 2;
    if (newest == 2) return 2'b10;
    if (newest == 1) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_for(input int src);
    if (src == 0) return "R5";
    if (xm_wr && int'(xm_rd) == src && mw_wr && int'(mw_rd) == src) return "R4";
    if (int'(xm_rd) == src && !xm_wr) return "R6";
    if (xm_wr && int'(xm_rd) == src) return "R2";
    if (mw_wr && int'(mw_rd) == src) return "R3";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (rs=%0d rt=%0d xm=%b/%0d mw=%b/%0d)",
               req, act, exp, ex_rs, ex_rt, xm_wr, xm_rd, mw_wr, mw_rd);
    end
  endtask

  task automatic check_all(input string note);
    logic st_exp;
    st_exp = xm_store && mw_load && mw_wr && mw_rd != 0 && mw_rd == xm_src;
    check({tag_for(int'(ex_rs)), " A ", note}, sel_a, ref_sel(int'(ex_rs)));
    check({tag_for(int'(ex_rt)), " B ", note}, sel_b, ref_sel(int'(ex_rt)));
    check({"R8 ", note}, {1'b0, sel_st}, {1'b0, st_exp});
  endtask

  task automatic drive(input int rs, input int rt, input bit xw, input int xd,
                       input bit xs, input int xsrc, input bit mwr, input int md,
                       input bit ml);
    @(negedge clk);
    ex_rs = AW'(rs); ex_rt = AW'(rt); xm_wr = xw; xm_rd = AW'(xd);
    xm_store = xs; xm_src = AW'(xsrc); mw_wr = mwr; mw_rd = AW'(md); mw_load = ml;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    ex_rs = '0; ex_rt = '0; xm_wr = 0; xm_rd = '0; xm_store = 0;
    xm_src = '0; mw_wr = 0; mw_rd = '0; mw_load = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1 check_all("reset state R1");

    // R1: no producer
    drive(3, 4, 1, 7, 0, 0, 1, 8, 0); #1 check_all("no match R1");
    // R2: exe/mem to A
    drive(6, 4, 1, 6, 0, 0, 0, 0, 0); #1 check_all("xm to A R2");
    // R3: mem/wb to B
    drive(2, 9, 0, 9, 0, 0, 1, 9, 0); #1 check_all("mw to B R3 R6");
    // R4: both stages write the same register
    drive(5, 5, 1, 5, 0, 0, 1, 5, 0); #1 check_all("both same R4");
    // R5: both stages write register zero
    drive(0, 0, 1, 0, 0, 0, 1, 0, 1); #1 check_all("zero dst R5");
    // R6: write flag clear with matching destination
    drive(11, 12, 0, 11, 0, 0, 0, 12, 0); #1 check_all("flags clear R6");
    // R7: A from exe/mem, B from mem/wb
    drive(13, 14, 1, 13, 0, 0, 1, 14, 0); #1 check_all("split R7");
    // R8: load then store of same register
    drive(1, 2, 0, 0, 1, 20, 1, 20, 1); #1 check_all("ld-st R8");
    // R8: same but not a load
    drive(1, 2, 0, 0, 1, 20, 1, 20, 0); #1 check_all("alu-st R8");
    // R8: load to register zero
    drive(1, 2, 0, 0, 1, 0, 1, 0, 1); #1 check_all("ld r0 R8 R5");
    // R9: change inputs mid-cycle, outputs follow without a clock edge
    @(negedge clk); #0.5 ex_rs = 5'd17; xm_wr = 1; xm_rd = 5'd17;
    #0.5 check_all("mid-cycle R9");

    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3),
            1'($urandom), $urandom_range(0, 3), 1'($urandom));
      #1 check_all("random R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule